// File: doc/BRIEF.md
# Mask-Filtered Receive Queue for CAN Frames

This block sits behind a CAN protocol engine and receives frames that are already decoded: identifier, data length code and eight data bytes, offered for one cycle with a valid strobe. Every frame is tested against a bank of acceptance filters. Each filter holds a compare value and a care mask for the identifier. A frame that no enabled filter accepts is discarded. A frame that some filter accepts is appended to one shared queue, together with the number of the filter that took it.

The host reads the oldest stored frame from the head outputs and removes it with a one-cycle pop strobe. Frames always leave in the order they arrived. An interrupt line can be armed from two sources, each with its own enable: the fill level reaching a programmed threshold, and the newest stored frame having come through a filter marked urgent. Frames that arrive while the queue is full are lost, and a sticky overflow flag records the loss.

Top module: `rxq_accept_fifo`

## Requirements
- R1: An enabled filter accepts a frame when `((fr_id ^ match) & mask) == 0`. A mask bit of 1 forces that identifier bit to equal the match bit, and a mask bit of 0 ignores it. A disabled filter accepts nothing.
- R2: When several filters accept a frame, the stored filter index is the lowest index that accepted it.
- R3: A frame that no filter accepts leaves the queue contents and `fill_level` unchanged.
- R4: An accepted frame is stored on the clock edge where `fr_valid` is high. From the next cycle `fill_level` is one higher, and when the frame is at the head, `rd_id`, `rd_dlc`, `rd_data` and `rd_fidx` show its identifier, DLC, data and accepting filter index.
- R5: Frames are read out strictly in arrival order. A frame from an urgent filter does not overtake frames stored before it.
- R6: Asserting `rd_pop` while `rd_valid` is high removes the head frame and lowers `fill_level` by one on that edge. A pop of an empty queue has no effect.
- R7: An accepted frame and a pop in the same cycle on a queue that is not full store the frame, remove the head and leave `fill_level` unchanged.
- R8: The queue holds DEPTH = 8 frames, which is 64 data bytes. A frame that is accepted while `fill_level` equals DEPTH is dropped, even if a pop happens in the same cycle. The drop sets `ovf_flag`, which stays high until `ovf_clr` is pulsed. If a drop and `ovf_clr` happen in the same cycle, the flag is set.
- R9: With `irq_lvl_en` high and `irq_thr` not 0, `irq` is high whenever `fill_level >= irq_thr`. With `irq_thr` = 1, every accepted frame raises `irq`. With `irq_thr` = 0 this source is silent.
- R10: With `irq_hi_en` high, `irq` is high while the newest stored frame came through a filter whose urgent bit is set. Storing a frame from a non-urgent filter clears this condition, and so does a pop that empties the queue.
- R11: After reset `fill_level` is 0, `rd_valid`, `ovf_flag` and `irq` are low, and all filters are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fr_valid | input | 1 | Decoded frame offered this cycle |
| fr_id | input | ID_W | Frame identifier |
| fr_dlc | input | 4 | Data length code |
| fr_data | input | 64 | Frame payload |
| flt_we | input | 1 | Write one filter slot |
| flt_sel | input | FIDX_W | Filter slot to write |
| flt_en | input | 1 | Enable bit written to the slot |
| flt_hipri | input | 1 | Urgent bit written to the slot |
| flt_match | input | ID_W | Compare value written to the slot |
| flt_mask | input | ID_W | Care mask written to the slot |
| irq_thr | input | LVL_W | Fill threshold for the level interrupt |
| irq_lvl_en | input | 1 | Arm the level interrupt source |
| irq_hi_en | input | 1 | Arm the urgent-filter interrupt source |
| rd_pop | input | 1 | Remove the head frame |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_valid | output | 1 | Queue not empty |
| rd_id | output | ID_W | Head frame identifier |
| rd_dlc | output | 4 | Head frame DLC |
| rd_data | output | 64 | Head frame payload |
| rd_fidx | output | FIDX_W | Index of the filter that accepted the head frame |
| fill_level | output | LVL_W | Number of stored frames |
| ovf_flag | output | 1 | Sticky frame-lost flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a frame arriving on a full queue in the same cycle as a pop. A queue model could easily accept that frame, but R8 says it must be dropped. The stimulus fills the queue with eight accepted frames from a wide filter. It then presents a ninth matching frame together with a pop, and expects the level to fall to seven and the overflow flag to rise. Draining the queue afterwards through the scoreboard shows that the ninth frame never entered it. A second hard case is overlapping filters: a narrow urgent filter is placed above a wide filter so that the lowest-index rule and the urgent interrupt flag can be told apart.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ID_W   = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    localparam int FRAME_W = $bits(rx_frame_t);
endpackage

// File: rtl/rxq_filter_bank.sv
module rxq_filter_bank
    import rxq_pkg::*;
#(
    parameter int NFILT  = 4,
    parameter int FIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FIDX_W-1:0] cfg_sel,
    input  logic              cfg_en,
    input  logic              cfg_hipri,
    input  logic [ID_W-1:0]   cfg_match,
    input  logic [ID_W-1:0]   cfg_mask,
    input  logic [ID_W-1:0]   id_i,
    output logic              hit_o,
    output logic [FIDX_W-1:0] hit_idx_o,
    output logic              hit_hipri_o
);
    typedef struct packed {
        logic            en;
        logic            hipri;
        logic [ID_W-1:0] match;
        logic [ID_W-1:0] mask;
    } flt_t;

    flt_t [NFILT-1:0] flt_d, flt_q;
    logic [NFILT-1:0] acc_vec;

    always_comb begin
        flt_d = flt_q;
        if (cfg_we && (int'(cfg_sel) < NFILT)) begin
            flt_d[cfg_sel].en    = cfg_en;
            flt_d[cfg_sel].hipri = cfg_hipri;
            flt_d[cfg_sel].match = cfg_match;
            flt_d[cfg_sel].mask  = cfg_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    for (genvar g = 0; g < NFILT; g++) begin : g_cmp
        assign acc_vec[g] = flt_q[g].en &&
                            (((id_i ^ flt_q[g].match) & flt_q[g].mask) == '0);
    end

    // lowest index wins: scan downward so the last assignment is the smallest hit
    always_comb begin
        hit_idx_o   = '0;
        hit_hipri_o = 1'b0;
        for (int i = NFILT - 1; i >= 0; i--) begin
            if (acc_vec[i]) begin
                hit_idx_o   = FIDX_W'(i);
                hit_hipri_o = flt_q[i].hipri;
            end
        end
    end

    assign hit_o = |acc_vec;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH   = 8,
    parameter int LVL_W   = 4,
    parameter int ENTRY_W = 81,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [ENTRY_W-1:0] push_data_i,
    input  logic               pop_i,
    input  logic               ovf_clr_i,
    output logic [ENTRY_W-1:0] head_o,
    output logic [LVL_W-1:0]   level_o,
    output logic               ovf_o,
    output logic               stored_o,
    output logic               removed_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
        logic             ovf;
    } st_t;

    st_t st_d, st_q;
    logic [ENTRY_W-1:0] mem_q [DEPTH];
    logic full, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (st_q.lvl == LVL_W'(DEPTH));
    assign push_ok = push_i && !full;
    assign pop_ok  = pop_i && (st_q.lvl != '0);

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wr = bump(st_q.wr);
        if (pop_ok)  st_d.rd = bump(st_q.rd);
        st_d.lvl = st_q.lvl + LVL_W'(push_ok) - LVL_W'(pop_ok);
        if (push_i && full)  st_d.ovf = 1'b1;
        else if (ovf_clr_i)  st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= push_data_i;
    end

    assign head_o    = mem_q[st_q.rd];
    assign level_o   = st_q.lvl;
    assign ovf_o     = st_q.ovf;
    assign stored_o  = push_ok;
    assign removed_o = pop_ok;
endmodule

// File: rtl/rxq_irq_ctl.sv
module rxq_irq_ctl #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stored_i,
    input  logic             stored_hipri_i,
    input  logic             removed_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thr_i,
    input  logic             lvl_en_i,
    input  logic             hi_en_i,
    output logic             irq_o
);
    typedef struct packed {
        logic hi;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stored_i)
            st_d.hi = stored_hipri_i;
        else if (removed_i && (level_i == LVL_W'(1)))
            st_d.hi = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = (lvl_en_i && (thr_i != '0) && (level_i >= thr_i)) ||
                   (hi_en_i && st_q.hi);
endmodule

// File: rtl/rxq_accept_fifo.sv
module rxq_accept_fifo
    import rxq_pkg::*;
#(
    parameter int NFILT    = 4,
    parameter int DEPTH    = 8,
    localparam int FIDX_W  = (NFILT > 1) ? $clog2(NFILT) : 1,
    localparam int LVL_W   = $clog2(DEPTH + 1),
    localparam int ENTRY_W = FRAME_W + FIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_valid,
    input  logic [ID_W-1:0]   fr_id,
    input  logic [DLC_W-1:0]  fr_dlc,
    input  logic [DATA_W-1:0] fr_data,
    input  logic              flt_we,
    input  logic [FIDX_W-1:0] flt_sel,
    input  logic              flt_en,
    input  logic              flt_hipri,
    input  logic [ID_W-1:0]   flt_match,
    input  logic [ID_W-1:0]   flt_mask,
    input  logic [LVL_W-1:0]  irq_thr,
    input  logic              irq_lvl_en,
    input  logic              irq_hi_en,
    input  logic              rd_pop,
    input  logic              ovf_clr,
    output logic              rd_valid,
    output logic [ID_W-1:0]   rd_id,
    output logic [DLC_W-1:0]  rd_dlc,
    output logic [DATA_W-1:0] rd_data,
    output logic [FIDX_W-1:0] rd_fidx,
    output logic [LVL_W-1:0]  fill_level,
    output logic              ovf_flag,
    output logic              irq
);
    logic              acc_hit, acc_hipri, stored, removed;
    logic [FIDX_W-1:0] acc_idx;
    logic [ENTRY_W-1:0] wr_entry, head_entry;
    rx_frame_t         in_frame, head_frame;

    rxq_filter_bank #(.NFILT(NFILT), .FIDX_W(FIDX_W)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(flt_we), .cfg_sel(flt_sel), .cfg_en(flt_en),
        .cfg_hipri(flt_hipri), .cfg_match(flt_match), .cfg_mask(flt_mask),
        .id_i(fr_id), .hit_o(acc_hit), .hit_idx_o(acc_idx),
        .hit_hipri_o(acc_hipri)
    );

    assign in_frame = '{id: fr_id, dlc: fr_dlc, data: fr_data};
    assign wr_entry = {in_frame, acc_idx};

    rxq_store #(.DEPTH(DEPTH), .LVL_W(LVL_W), .ENTRY_W(ENTRY_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_i(fr_valid && acc_hit), .push_data_i(wr_entry),
        .pop_i(rd_pop), .ovf_clr_i(ovf_clr),
        .head_o(head_entry), .level_o(fill_level), .ovf_o(ovf_flag),
        .stored_o(stored), .removed_o(removed)
    );

    rxq_irq_ctl #(.LVL_W(LVL_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .stored_i(stored), .stored_hipri_i(acc_hipri), .removed_i(removed),
        .level_i(fill_level), .thr_i(irq_thr),
        .lvl_en_i(irq_lvl_en), .hi_en_i(irq_hi_en), .irq_o(irq)
    );

    assign head_frame = head_entry[ENTRY_W-1:FIDX_W];
    assign rd_fidx    = head_entry[FIDX_W-1:0];
    assign rd_id      = head_frame.id;
    assign rd_dlc     = head_frame.dlc;
    assign rd_data    = head_frame.data;
    assign rd_valid   = (fill_level != '0);
endmodule

// File: rtl/rxq_accept_fifo_chk.sv
module rxq_accept_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fr_valid,
    input logic             acc_hit,
    input logic             rd_pop,
    input logic             rd_valid,
    input logic             ovf_clr,
    input logic             ovf_flag,
    input logic [LVL_W-1:0] fill_level,
    input logic             irq_lvl_en,
    input logic             irq_hi_en,
    input logic             irq
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH)); // R8

    AST_NOMATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && !acc_hit && !(rd_pop && rd_valid))
        |=> (fill_level == $past(fill_level))); // R3

    AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && rd_valid && !(fr_valid && acc_hit))
        |=> (fill_level == $past(fill_level) - LVL_W'(1))); // R6

    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && acc_hit && rd_pop && rd_valid && fill_level != LVL_W'(DEPTH))
        |=> $stable(fill_level)); // R7

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && acc_hit && fill_level == LVL_W'(DEPTH)) |=> ovf_flag); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_lvl_en && !irq_hi_en) |-> !irq); // R9
endmodule

bind rxq_accept_fifo rxq_accept_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .acc_hit(acc_hit),
    .rd_pop(rd_pop), .rd_valid(rd_valid), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag), .fill_level(fill_level),
    .irq_lvl_en(irq_lvl_en), .irq_hi_en(irq_hi_en), .irq(irq)
);

// File: tb/test_rxq_accept_fifo.sv
module test_rxq_accept_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fr_valid = 0;
    logic [10:0] fr_id = '0;
    logic [3:0]  fr_dlc = '0;
    logic [63:0] fr_data = '0;
    logic        flt_we = 0;
    logic [1:0]  flt_sel = '0;
    logic        flt_en = 0, flt_hipri = 0;
    logic [10:0] flt_match = '0, flt_mask = '0;
    logic [3:0]  irq_thr = '0;
    logic        irq_lvl_en = 0, irq_hi_en = 0;
    logic        rd_pop = 0, ovf_clr = 0;
    logic        rd_valid, ovf_flag, irq;
    logic [10:0] rd_id;
    logic [3:0]  rd_dlc;
    logic [63:0] rd_data;
    logic [1:0]  rd_fidx;
    logic [3:0]  fill_level;

    rxq_accept_fifo i_rxq_accept_fifo (
        .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_id(fr_id),
        .fr_dlc(fr_dlc), .fr_data(fr_data), .flt_we(flt_we), .flt_sel(flt_sel),
        .flt_en(flt_en), .flt_hipri(flt_hipri), .flt_match(flt_match),
        .flt_mask(flt_mask), .irq_thr(irq_thr), .irq_lvl_en(irq_lvl_en),
        .irq_hi_en(irq_hi_en), .rd_pop(rd_pop), .ovf_clr(ovf_clr),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_dlc(rd_dlc), .rd_data(rd_data),
        .rd_fidx(rd_fidx), .fill_level(fill_level), .ovf_flag(ovf_flag), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [10:0] id;
        logic [3:0]  dlc;
        logic [63:0] data;
        int          fidx;
    } exp_t;

    exp_t sb[$];
    int checks = 0, errors = 0;
    bit m_en[4], m_hip[4];
    logic [10:0] m_match[4], m_mask[4];
    bit m_ovf = 0, m_hi = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [10:0] id);
        for (int i = 0; i < 4; i++)
            if (m_en[i] && (((id ^ m_match[i]) & m_mask[i]) == 11'd0)) return i;
        return -1;
    endfunction

    task automatic check_state(input string tag);
        bit exp_irq;
        exp_irq = (irq_lvl_en && irq_thr != 0 && sb.size() >= int'(irq_thr)) ||
                  (irq_hi_en && m_hi);
        chk(fill_level == 4'(sb.size()), tag, "fill_level", 64'(fill_level), 64'(sb.size()));
        chk(rd_valid == (sb.size() != 0), tag, "rd_valid", 64'(rd_valid), 64'(sb.size() != 0));
        chk(ovf_flag == m_ovf, tag, "ovf_flag", 64'(ovf_flag), 64'(m_ovf));
        chk(irq == exp_irq, tag, "irq", 64'(irq), 64'(exp_irq));
    endtask

    // driver: offers one frame and/or pop; scoreboard compares the popped head
    task automatic cyc(input bit v, input logic [10:0] id, input bit p, input string tag);
        int fi;
        bit stored, popped;
        exp_t e;
        if (p && sb.size() > 0) begin
            chk(rd_id == sb[0].id, tag, "rd_id", 64'(rd_id), 64'(sb[0].id));
            chk(rd_dlc == sb[0].dlc, tag, "rd_dlc", 64'(rd_dlc), 64'(sb[0].dlc));
            chk(rd_data == sb[0].data, tag, "rd_data", rd_data, sb[0].data);
            chk(int'(rd_fidx) == sb[0].fidx, tag, "rd_fidx", 64'(rd_fidx), 64'(sb[0].fidx));
        end
        fr_valid = v;
        fr_id    = id;
        fr_dlc   = 4'(id[3:0] ^ 4'h5);
        fr_data  = {id, 53'h1A2B3C4D5E6F7} ^ {64{id[0]}};
        rd_pop   = p;
        fi       = v ? m_find(id) : -1;
        stored   = 0;
        popped   = p && (sb.size() > 0);
        if (fi >= 0) begin
            if (sb.size() == DEPTH) m_ovf = 1;
            else                    stored = 1;
        end
        if (popped) void'(sb.pop_front());
        if (stored) begin
            e.id = id; e.dlc = fr_dlc; e.data = fr_data; e.fidx = fi;
            sb.push_back(e);
            m_hi = m_hip[fi];
        end else if (popped && sb.size() == 0) begin
            m_hi = 0;
        end
        @(negedge clk);
        fr_valid = 0;
        rd_pop   = 0;
        check_state(tag);
    endtask

    task automatic cfg_flt(input int idx, input bit en, input bit hi,
                           input logic [10:0] mt, input logic [10:0] mk);
        flt_we = 1; flt_sel = 2'(idx); flt_en = en; flt_hipri = hi;
        flt_match = mt; flt_mask = mk;
        m_en[idx] = en; m_hip[idx] = hi; m_match[idx] = mt; m_mask[idx] = mk;
        @(negedge clk);
        flt_we = 0;
    endtask

    task automatic drain(input string tag);
        while (sb.size() > 0) cyc(0, 11'h0, 1, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_en[i] = 0; m_hip[i] = 0; m_match[i] = '0; m_mask[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_state("R11");
        cyc(1, 11'h120, 0, "R11");           // no filter enabled yet: dropped

        cfg_flt(0, 1, 0, 11'h120, 11'h7F0);  // wide window 0x120..0x12F
        cfg_flt(1, 1, 1, 11'h200, 11'h7FF);  // urgent exact id
        cfg_flt(2, 1, 0, 11'h120, 11'h7FF);  // overlaps filter 0
        cfg_flt(3, 0, 1, 11'h300, 11'h7FF);  // disabled

        cyc(1, 11'h12F, 0, "R1");            // don't-care low nibble
        cyc(1, 11'h130, 0, "R1");            // cared bit differs
        cyc(1, 11'h300, 0, "R1");            // only disabled filter fits
        cyc(1, 11'h120, 0, "R2");            // filters 0 and 2: index 0
        cyc(1, 11'h555, 0, "R3");
        cyc(1, 11'h200, 0, "R4");
        cyc(0, 11'h0, 1, "R5");
        cyc(0, 11'h0, 1, "R5");
        cyc(0, 11'h0, 1, "R4");
        cyc(0, 11'h0, 1, "R6");              // pop of empty queue

        irq_hi_en = 1;
        cyc(1, 11'h200, 0, "R10");
        cyc(1, 11'h121, 0, "R10");
        cyc(1, 11'h200, 0, "R10");
        cyc(1, 11'h125, 1, "R7");            // push and pop together at level 3
        cyc(1, 11'h200, 0, "R10");
        cyc(0, 11'h0, 1, "R5");              // urgent frame still waits its turn
        drain("R10");
        irq_hi_en = 0;

        irq_lvl_en = 1; irq_thr = 4'd3;
        cyc(1, 11'h122, 0, "R9");
        cyc(1, 11'h123, 0, "R9");
        cyc(1, 11'h124, 0, "R9");
        cyc(0, 11'h0, 1, "R9");
        drain("R9");
        irq_thr = 4'd1;
        cyc(1, 11'h126, 0, "R9");
        cyc(0, 11'h0, 1, "R9");
        irq_thr = 4'd0;
        cyc(1, 11'h127, 0, "R9");
        drain("R9");
        irq_lvl_en = 0;

        for (int i = 0; i < DEPTH; i++) cyc(1, 11'(11'h120 + i), 0, "R8");
        cyc(1, 11'h12E, 1, "R8");            // full + pop: still dropped
        cyc(1, 11'h12D, 0, "R8");            // level 7: stored
        cyc(1, 11'h12C, 0, "R8");            // full again: dropped
        cyc(1, 11'h777, 0, "R8");            // unmatched: flag holds
        ovf_clr = 1; m_ovf = 0;
        @(negedge clk);
        ovf_clr = 0;
        check_state("R8");
        drain("R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule